// File: doc/BRIEF.md
# Cycle and Profiling Counter Unit

This block is a small memory-mapped performance counter unit for a processor core. It holds one free-running cycle counter and five short profiling counters. Each profiling counter has its own event strobe from the core. The strobes count extra instruction cycles, exception-entry overhead cycles, sleep cycles, extra load/store cycles, and instructions that retire in zero cycles. The cycle counter runs only while a local enable bit is set and a global trace-enable input from the debug logic is high.

Software reaches the unit through a simple single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the word index. Software can preload or clear any counter. It can also enable, separately for each profiling counter, a one-cycle overflow event pulse that fires when that counter wraps. The control register also reports read-only presence flags and a comparator count, so software can discover what the unit provides.

Register word indices: 0 is control, 1 is the cycle counter, and 2 to 6 are profiling counters 0 to 4, in the order extra-instruction, exception, sleep, load/store, folded. Control bit 0 is the cycle enable. Bits 5:1 are the overflow enables for profiling counters 0 to 4. Bit 8 is the profiling-absent flag and bit 9 is the cycle-absent flag. Bits 31:28 give the comparator count.

Top module: `perf_cnt_unit`

## Requirements
- R1: After reset, the following all read zero: the cycle counter, every profiling counter, every control enable and every overflow output.
- R2: The cycle counter increases by exactly one at a clock edge only when control bit 0 and `trc_en` are both 1; otherwise it holds.
- R3: The cycle counter wraps from all-ones to zero.
- R4: Profiling counter i (0 extra-instruction, 1 exception, 2 sleep, 3 load/store, 4 folded) increases by one at each edge where `prof_evt[i]` is 1, whatever the state of `trc_en`.
- R5: When a profiling counter wraps from 255 to 0 and its overflow enable (control bit 1+i) is set, `ovf_evt[i]` is 1 for exactly the one cycle in which the counter reads 0.
- R6: A wrap of a profiling counter whose overflow enable is clear produces no pulse on `ovf_evt`.
- R7: A bus write to a counter replaces its value and overrides an increment in the same cycle. A profiling counter takes `bus_wdata[7:0]`.
- R8: A read returns the addressed register as laid out above, zero-extended. Word index 7 reads 0.
- R9: Control bits 5:0 are writable. Bits 31:28 read the comparator count (4 by default). Bits 8 and 9 read 0 when their counters are present. All other bits read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trc_en | input | 1 | Global trace enable that gates the cycle counter |
| prof_evt | input | NUM_PROF | Per-cycle event strobes, one per profiling counter |
| bus_we | input | 1 | Register write strobe |
| bus_widx | input | WIDX_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_widx` |
| cyc_count | output | CYC_W | Cycle counter value |
| prof_count | output | NUM_PROF*PROF_W | Profiling counters, counter i at bits i*PROF_W |
| ovf_evt | output | NUM_PROF | One-cycle overflow pulses |

## Verification
The bench builds the unit with its default parameters: a 32-bit cycle counter, five 8-bit profiling counters and four comparators reported. Preloading a counter through the register port brings both wrap points within a few cycles, so there is no need to count through 2^32. Random strobes and occasional random preloads of 0xFF then make the 255-to-0 wrap common, with the overflow enable sometimes set and sometimes clear. Directed steps cover a write colliding with an increment, and `trc_en` low while the local enable is set.

// File: rtl/perf_cnt_pkg.sv
`timescale 1ns/1ps
package perf_cnt_pkg;
  // register word indices
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_CYC   = 1;
  localparam int unsigned REG_PROF0 = 2;

  // control register layout
  localparam int unsigned CTL_CYC_EN      = 0;
  localparam int unsigned CTL_OVF_LSB     = 1;
  localparam int unsigned CTL_PROF_ABSENT = 8;
  localparam int unsigned CTL_CYC_ABSENT  = 9;
  localparam int unsigned NCMP_W          = 4;
endpackage

// File: rtl/perf_ctrl_reg.sv
`timescale 1ns/1ps
module perf_ctrl_reg
  import perf_cnt_pkg::*;
#(
  parameter int unsigned NUM_PROF = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CMP  = 4,
  parameter int unsigned HAS_CYC  = 1,
  parameter int unsigned HAS_PROF = 1,
  localparam int unsigned EN_W    = NUM_PROF + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [EN_W-1:0]     wdata,
  output logic                cyc_en,
  output logic [NUM_PROF-1:0] ovf_en,
  output logic [DATA_W-1:0]   rdata
);
  localparam logic [EN_W-1:0] WR_MASK = {{NUM_PROF{(HAS_PROF != 0)}}, (HAS_CYC != 0)};

  logic [EN_W-1:0] en_q;
  logic [EN_W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr) en_d = wdata & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= en_d;
  end

  assign cyc_en = en_q[CTL_CYC_EN];
  assign ovf_en = en_q[CTL_OVF_LSB +: NUM_PROF];

  always_comb begin
    rdata                          = '0;
    rdata[EN_W-1:0]                = en_q;
    rdata[CTL_PROF_ABSENT]         = (HAS_PROF == 0);
    rdata[CTL_CYC_ABSENT]          = (HAS_CYC == 0);
    rdata[DATA_W-1 -: NCMP_W]      = NCMP_W'(NUM_CMP);
  end

  // R9
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));
endmodule

// File: rtl/perf_cyc_ctr.sv
`timescale 1ns/1ps
module perf_cyc_ctr #(
  parameter int unsigned CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             trc_en,
  input  logic             wr,
  input  logic [CYC_W-1:0] wdata,
  output logic [CYC_W-1:0] count
);
  logic             inc;
  logic             ld;
  logic [CYC_W-1:0] cnt_q;
  logic [CYC_W-1:0] cnt_d;

  assign inc = cnt_en & trc_en;
  assign ld  = wr | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (wr)       cnt_d = wdata;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ld) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R2
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !(cnt_en && trc_en)) |=> $stable(count));
  // R3
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && cnt_en && trc_en) |=> (count == $past(count) + 1'b1));
  // R7
  cyc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (count == $past(wdata)));
endmodule

// File: rtl/perf_prof_ctr.sv
`timescale 1ns/1ps
module perf_prof_ctr #(
  parameter int unsigned PROF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              ovf_en,
  input  logic              wr,
  input  logic [PROF_W-1:0] wdata,
  output logic [PROF_W-1:0] count,
  output logic              ovf
);
  logic [PROF_W-1:0] cnt_q;
  logic [PROF_W-1:0] cnt_d;
  logic              ld;
  logic              wrap;
  logic              ovf_q;
  logic              ovf_d;

  assign ld    = wr | evt;
  assign wrap  = evt & ~wr & (&cnt_q);
  assign ovf_d = wrap & ovf_en;

  always_comb begin
    cnt_d = cnt_q;
    if (wr)       cnt_d = wdata;
    else if (evt) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      if (ld) cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R4
  prof_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !wr) |=> (count == $past(count) + 1'b1));
  // R5
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0));
  // R6
  ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(ovf_en));
  // R5
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);
endmodule

// File: rtl/perf_cnt_unit.sv
`timescale 1ns/1ps
module perf_cnt_unit
  import perf_cnt_pkg::*;
#(
  parameter int unsigned CYC_W    = 32,
  parameter int unsigned PROF_W   = 8,
  parameter int unsigned NUM_PROF = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WIDX_W   = 3,
  parameter int unsigned NUM_CMP  = 4,
  parameter int unsigned HAS_CYC  = 1,
  parameter int unsigned HAS_PROF = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trc_en,
  input  logic [NUM_PROF-1:0]        prof_evt,
  input  logic                       bus_we,
  input  logic [WIDX_W-1:0]          bus_widx,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [CYC_W-1:0]           cyc_count,
  output logic [NUM_PROF*PROF_W-1:0] prof_count,
  output logic [NUM_PROF-1:0]        ovf_evt
);
  localparam int unsigned EN_W = NUM_PROF + 1;

  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // write decode
  logic                wr_ctrl;
  logic                wr_cyc;
  logic [NUM_PROF-1:0] wr_prof;

  assign wr_ctrl = bus_we && (bus_widx == WIDX_W'(REG_CTRL));
  assign wr_cyc  = bus_we && (bus_widx == WIDX_W'(REG_CYC));

  logic                cyc_en;
  logic [NUM_PROF-1:0] ovf_en;
  logic [DATA_W-1:0]   ctrl_rdata;

  perf_ctrl_reg #(
    .NUM_PROF (NUM_PROF),
    .DATA_W   (DATA_W),
    .NUM_CMP  (NUM_CMP),
    .HAS_CYC  (HAS_CYC),
    .HAS_PROF (HAS_PROF)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr     (wr_ctrl),
    .wdata  (bus_wdata[EN_W-1:0]),
    .cyc_en (cyc_en),
    .ovf_en (ovf_en),
    .rdata  (ctrl_rdata)
  );

  logic [CYC_W-1:0] cyc_q;

  generate
    if (HAS_CYC != 0) begin : g_cyc
      perf_cyc_ctr #(.CYC_W(CYC_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n_s),
        .cnt_en (cyc_en),
        .trc_en (trc_en),
        .wr     (wr_cyc),
        .wdata  (bus_wdata[CYC_W-1:0]),
        .count  (cyc_q)
      );
    end else begin : g_no_cyc
      assign cyc_q = '0;
    end
  endgenerate

  logic [PROF_W-1:0] prof_q [NUM_PROF];

  generate
    for (genvar i = 0; i < NUM_PROF; i++) begin : g_prof
      assign wr_prof[i] = bus_we && (bus_widx == WIDX_W'(REG_PROF0 + i));
      if (HAS_PROF != 0) begin : g_on
        perf_prof_ctr #(.PROF_W(PROF_W)) u_prof (
          .clk    (clk),
          .rst_n  (rst_n_s),
          .evt    (prof_evt[i]),
          .ovf_en (ovf_en[i]),
          .wr     (wr_prof[i]),
          .wdata  (bus_wdata[PROF_W-1:0]),
          .count  (prof_q[i]),
          .ovf    (ovf_evt[i])
        );
      end else begin : g_off
        assign prof_q[i]  = '0;
        assign ovf_evt[i] = 1'b0;
      end
      assign prof_count[i*PROF_W +: PROF_W] = prof_q[i];
    end
  endgenerate

  assign cyc_count = cyc_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_widx == WIDX_W'(REG_CTRL)) begin
      bus_rdata = ctrl_rdata;
    end else if (bus_widx == WIDX_W'(REG_CYC)) begin
      bus_rdata[CYC_W-1:0] = cyc_q;
    end else begin
      for (int i = 0; i < NUM_PROF; i++) begin
        if (bus_widx == WIDX_W'(REG_PROF0 + i)) bus_rdata[PROF_W-1:0] = prof_q[i];
      end
    end
  end

  // R8
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_widx >= WIDX_W'(REG_PROF0 + NUM_PROF)) |-> (bus_rdata == '0));
endmodule

// File: tb/perf_cnt_unit_bench.sv
`timescale 1ns/1ps
module perf_cnt_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        trc_en;
  logic [4:0]  prof_evt;
  logic        bus_we;
  logic [2:0]  bus_widx;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] cyc_count;
  logic [39:0] prof_count;
  logic [4:0]  ovf_evt;

  perf_cnt_unit u_perf_cnt_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .trc_en     (trc_en),
    .prof_evt   (prof_evt),
    .bus_we     (bus_we),
    .bus_widx   (bus_widx),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cyc_count  (cyc_count),
    .prof_count (prof_count),
    .ovf_evt    (ovf_evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk;
  int n_err;
  bit done;

  // model state
  logic [31:0] m_cyc;
  logic [7:0]  m_prof [5];
  logic [5:0]  m_ctl;
  logic [4:0]  m_ovf;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] idx);
    case (idx)
      3'd0:    return 32'h4000_0000 | {26'd0, m_ctl};
      3'd1:    return m_cyc;
      3'd7:    return 32'd0;
      default: return {24'd0, m_prof[idx - 3'd2]};
    endcase
  endfunction

  task automatic model_update(input logic we, input logic [2:0] idx, input logic [31:0] wd,
                              input logic [4:0] ev, input logic trc);
    m_ovf = '0;
    for (int i = 0; i < 5; i++) begin
      if (we && idx == 3'(i + 2)) m_prof[i] = wd[7:0];
      else if (ev[i]) begin
        if (m_prof[i] == 8'hFF && m_ctl[1+i]) m_ovf[i] = 1'b1;
        m_prof[i] = m_prof[i] + 8'd1;
      end
    end
    if (we && idx == 3'd1)     m_cyc = wd;
    else if (m_ctl[0] && trc)  m_cyc = m_cyc + 32'd1;
    if (we && idx == 3'd0)     m_ctl = wd[5:0];
  endtask

  task automatic compare_all();
    check(cyc_count, m_cyc, "R2 cycle count");
    for (int i = 0; i < 5; i++) begin
      check({24'd0, prof_count[i*8 +: 8]}, {24'd0, m_prof[i]}, "R4 profiling count");
    end
    check({27'd0, ovf_evt}, {27'd0, m_ovf}, "R5 overflow pulses");
  endtask

  task automatic step(input logic we, input logic [2:0] idx, input logic [31:0] wd,
                      input logic [4:0] ev, input logic trc);
    bus_we    = we;
    bus_widx  = idx;
    bus_wdata = wd;
    prof_evt  = ev;
    trc_en    = trc;
    @(posedge clk);
    #2;
    model_update(we, idx, wd, ev, trc);
    bus_we   = 1'b0;
    prof_evt = '0;
    compare_all();
  endtask

  task automatic peek(input logic [2:0] idx, input string tag);
    bus_widx = idx;
    #1;
    check(bus_rdata, exp_rd(idx), tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired before R1..end of sequence");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    m_cyc = '0; m_ctl = '0; m_ovf = '0;
    for (int i = 0; i < 5; i++) m_prof[i] = '0;
    rst_n = 1'b0; trc_en = 1'b0; prof_evt = '0;
    bus_we = 1'b0; bus_widx = '0; bus_wdata = '0;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;

    // R1: reset state
    check(cyc_count, 32'd0, "R1 cycle count");
    check(prof_count[31:0], 32'd0, "R1 profiling counts");
    check({24'd0, prof_count[39:32]}, 32'd0, "R1 profiling counts");
    check({27'd0, ovf_evt}, 32'd0, "R1 overflow");
    for (int k = 0; k < 8; k++) peek(3'(k), "R1 R8 read after reset");

    // R9: only writable bits stick, read-only fields unchanged
    step(1'b1, 3'd0, 32'hFFFF_FFFF, 5'd0, 1'b0);
    bus_widx = 3'd0; #1;
    check(bus_rdata, 32'h4000_003F, "R9 control readback");
    step(1'b1, 3'd0, 32'h0000_0001, 5'd0, 1'b0);

    // R2: trace enable gates the cycle counter
    for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 32'd0, 5'd0, 1'b0);
    check(cyc_count, 32'd0, "R2 held with trc_en low");
    for (int k = 0; k < 4; k++) step(1'b0, 3'd0, 32'd0, 5'd0, 1'b1);
    check(cyc_count, 32'd4, "R2 counts with both enables");

    // R3: wrap of the cycle counter
    step(1'b1, 3'd1, 32'hFFFF_FFFE, 5'd0, 1'b1);
    step(1'b0, 3'd0, 32'd0, 5'd0, 1'b1);
    check(cyc_count, 32'hFFFF_FFFF, "R3 before wrap");
    step(1'b0, 3'd0, 32'd0, 5'd0, 1'b1);
    check(cyc_count, 32'd0, "R3 after wrap");

    // R7: write beats increment
    step(1'b1, 3'd5, 32'h0000_0010, 5'b01000, 1'b1);
    check({24'd0, prof_count[31:24]}, 32'h10, "R7 profiling write wins");
    step(1'b1, 3'd1, 32'd5, 5'd0, 1'b1);
    check(cyc_count, 32'd5, "R7 cycle write wins");

    // R6: wrap with overflow disabled
    step(1'b1, 3'd2, 32'hFF, 5'd0, 1'b0);
    step(1'b0, 3'd0, 32'd0, 5'b00001, 1'b0);
    check({24'd0, prof_count[7:0]}, 32'd0, "R6 counter wrapped");
    check({31'd0, ovf_evt[0]}, 32'd0, "R6 no pulse when disabled");

    // R5: wrap with overflow enabled, single pulse
    step(1'b1, 3'd0, 32'h3F, 5'd0, 1'b0);
    step(1'b1, 3'd6, 32'hFF, 5'd0, 1'b0);
    step(1'b0, 3'd0, 32'd0, 5'b10000, 1'b0);
    check({31'd0, ovf_evt[4]}, 32'd1, "R5 pulse on wrap");
    step(1'b0, 3'd0, 32'd0, 5'd0, 1'b0);
    check({31'd0, ovf_evt[4]}, 32'd0, "R5 pulse lasts one cycle");

    // R4: all strobes, trace enable low
    for (int k = 0; k < 3; k++) step(1'b0, 3'd0, 32'd0, 5'b11111, 1'b0);
    check({24'd0, prof_count[23:16]}, 32'd3, "R4 sleep counter");

    // R8: unmapped index
    peek(3'd7, "R8 unmapped read");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic        we;
      logic [2:0]  idx;
      logic [31:0] wd;
      we  = (($urandom % 12) == 0);
      idx = 3'($urandom % 7);
      if (idx >= 3'd2)      wd = ($urandom % 2 == 0) ? 32'hFF : $urandom;
      else if (idx == 3'd1) wd = ($urandom % 2 == 0) ? 32'hFFFF_FFF0 : $urandom;
      else                  wd = $urandom;
      step(we, idx, wd, 5'($urandom), (($urandom % 4) != 0));
      peek(3'($urandom % 8), "R8 random read");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule